// File: doc/BRIEF.md
# Stereo DAC Zero-Run Mute and Shared-Pin Controller

This block sits on the sample path of a two-channel audio DAC, just ahead of the modulator. It takes left and right signed samples, each qualified by a sample strobe, and registers them towards the modulator. It drives both channels to the bipolar zero code, which is all zeros for two's-complement data, in two cases. The first is when the converter is switched off by a control bit. The second is when automatic muting is enabled and both channels have carried nothing but zero for a long unbroken run of samples.

Each channel keeps its own count of consecutive zero samples. That count raises a per-channel zero flag. Two shared pins normally carry the left and right one-bit stream data into the block. A pin-function bit can turn them round so that they carry the two zero flags out instead. The block also picks the one-bit stream source. In filter-bypass mode this is either the single parallel-path input fed to both channels, or the two shared pins as a stereo pair. In bitstream mode the source is the two shared pins. All control bits are treated as static register values.

Top module: `dac_zero_mute`

## Requirements
- R1: After reset, both sample outputs are 0, mute is 0, both zero flags are 0 and both pad output enables are 0.
- R2: A sample pair presented with smp_valid high on a rising edge appears on out_left and out_right from the following cycle, while the block is not muted.
- R3: While dac_off is 1, out_left and out_right are 0 and mute is 1, whatever samples arrive. Clearing dac_off shows the last registered pair again.
- R4: With amute_en at 0, no run of zero samples of any length raises mute.
- R5: With amute_en at 1 and dsd_mode at 0, mute rises in the cycle after the strobe that completes ZERO_RUN (default 1024) consecutive strobes on which both channels were zero. It does not rise after ZERO_RUN-1 such strobes, and a run that one channel broke only counts from that break.
- R6: A strobe carrying a nonzero sample on either channel clears an automatic mute in the very next cycle, and that sample is shown at once.
- R7: While dsd_mode is 1, automatic muting never acts, even with amute_en at 1 and both channels past the zero run.
- R8: Each channel's zero flag is 1 once that channel has seen ZERO_RUN consecutive zero strobes. It stays 1 through any longer run because the count saturates without wrapping, and a nonzero strobe on that channel clears it.
- R9: With pin_out_sel at 0, both pad output enables are 0 and both pad outputs are 0. With pin_out_sel at 1, both enables are 1 and pad_l_out/pad_r_out carry the left/right zero flags.
- R10: In filter-bypass mode (fbyp_mode=1, which takes priority over dsd_mode), stereo_sel=0 routes par_bit to both bs_left and bs_right, and stereo_sel=1 routes pad_l_in to bs_left and pad_r_in to bs_right. In bitstream mode (dsd_mode=1, fbyp_mode=0) the pads feed bs_left/bs_right. With neither mode active, both stream outputs are 0.
- R11: While pin_out_sel is 1, the pad inputs are not used as data: any stream bit that would come from a pad is 0.
- R12: Sample inputs presented while smp_valid is 0 change neither the outputs nor the zero counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample strobe |
| pcm_left | input | DATA_W | Left signed sample |
| pcm_right | input | DATA_W | Right signed sample |
| dac_off | input | 1 | Converter disable, forces bipolar zero |
| amute_en | input | 1 | Zero-run auto-mute enable |
| dsd_mode | input | 1 | One-bit stream input mode |
| fbyp_mode | input | 1 | Filter-bypass mode |
| stereo_sel | input | 1 | Stereo source select in bypass mode |
| pin_out_sel | input | 1 | Shared pins carry zero flags out |
| par_bit | input | 1 | Parallel-path one-bit data input |
| pad_l_in | input | 1 | Left shared pin, input side |
| pad_r_in | input | 1 | Right shared pin, input side |
| out_left | output | DATA_W | Left sample to modulator |
| out_right | output | DATA_W | Right sample to modulator |
| mute | output | 1 | Outputs forced to bipolar zero |
| zflag_left | output | 1 | Left zero-run flag |
| zflag_right | output | 1 | Right zero-run flag |
| pad_l_out | output | 1 | Left shared pin, output side |
| pad_r_out | output | 1 | Right shared pin, output side |
| pad_l_oe | output | 1 | Left shared pin output enable |
| pad_r_oe | output | 1 | Right shared pin output enable |
| bs_left | output | 1 | Selected left one-bit stream |
| bs_right | output | 1 | Selected right one-bit stream |

## Verification
Pass-through is tried with mixed-sign pairs, full-scale codes, and pairs where only one side is zero. These show whether each channel is registered independently and whether a lone zero is mistaken for silence. Zero runs of exactly ZERO_RUN-1 and ZERO_RUN strobes separate a correct threshold from an off-by-one. A run that the right channel breaks while the left is already saturated shows whether muting demands joint silence rather than two separate runs. Long runs past the threshold expose a counter that wraps. A single nonzero strobe on one side checks immediate release. Stream routing is walked through every mode and pin-direction combination, with pad values chosen so that each source is told apart.

// File: rtl/dac_zero_mute.sv
module dac_zero_mute #(
  parameter int DATA_W   = 24,
  parameter int ZERO_RUN = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] pcm_left,
  input  logic [DATA_W-1:0] pcm_right,
  input  logic              dac_off,
  input  logic              amute_en,
  input  logic              dsd_mode,
  input  logic              fbyp_mode,
  input  logic              stereo_sel,
  input  logic              pin_out_sel,
  input  logic              par_bit,
  input  logic              pad_l_in,
  input  logic              pad_r_in,
  output logic [DATA_W-1:0] out_left,
  output logic [DATA_W-1:0] out_right,
  output logic              mute,
  output logic              zflag_left,
  output logic              zflag_right,
  output logic              pad_l_out,
  output logic              pad_r_out,
  output logic              pad_l_oe,
  output logic              pad_r_oe,
  output logic              bs_left,
  output logic              bs_right
);
  localparam int CNT_W = $clog2(ZERO_RUN + 1);
  localparam logic [CNT_W-1:0] RUN_END = CNT_W'(ZERO_RUN);

  logic [DATA_W-1:0] held_l, held_r;
  logic [CNT_W-1:0]  zcnt_l, zcnt_r;
  logic              auto_mute;
  logic              pad_l_data, pad_r_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_l <= '0;
      held_r <= '0;
      zcnt_l <= '0;
      zcnt_r <= '0;
    end else if (smp_valid) begin
      held_l <= pcm_left;
      held_r <= pcm_right;
      if (pcm_left != '0)       zcnt_l <= '0;
      else if (zcnt_l != RUN_END) zcnt_l <= zcnt_l + 1'b1;
      if (pcm_right != '0)      zcnt_r <= '0;
      else if (zcnt_r != RUN_END) zcnt_r <= zcnt_r + 1'b1;
    end
  end

  assign zflag_left  = (zcnt_l == RUN_END);
  assign zflag_right = (zcnt_r == RUN_END);
  assign auto_mute   = amute_en && !dsd_mode && zflag_left && zflag_right;
  assign mute        = dac_off || auto_mute;
  assign out_left    = mute ? '0 : held_l;
  assign out_right   = mute ? '0 : held_r;

  assign pad_l_oe   = pin_out_sel;
  assign pad_r_oe   = pin_out_sel;
  assign pad_l_out  = pin_out_sel && zflag_left;
  assign pad_r_out  = pin_out_sel && zflag_right;
  assign pad_l_data = !pin_out_sel && pad_l_in;
  assign pad_r_data = !pin_out_sel && pad_r_in;

  always_comb begin
    if (fbyp_mode) begin
      bs_left  = stereo_sel ? pad_l_data : par_bit;
      bs_right = stereo_sel ? pad_r_data : par_bit;
    end else if (dsd_mode) begin
      bs_left  = pad_l_data;
      bs_right = pad_r_data;
    end else begin
      bs_left  = 1'b0;
      bs_right = 1'b0;
    end
  end
endmodule

// File: rtl/dac_zero_mute_chk.sv
module dac_zero_mute_chk #(
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic [DATA_W-1:0] pcm_left,
  input logic [DATA_W-1:0] pcm_right,
  input logic              dac_off,
  input logic              amute_en,
  input logic              dsd_mode,
  input logic [DATA_W-1:0] out_left,
  input logic [DATA_W-1:0] out_right,
  input logic              mute,
  input logic              zflag_left,
  input logic              pad_l_out,
  input logic              pad_r_out,
  input logic              pad_l_oe,
  input logic              pad_r_oe,
  input logic [DATA_W-1:0] held_l
);
  p_off_forces_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dac_off |-> (mute && out_left == '0 && out_right == '0));

  p_no_auto_mute_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!amute_en && !dac_off) |-> !mute);

  p_dsd_suppress_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dsd_mode && !dac_off) |-> !mute);

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && (pcm_left != '0 || pcm_right != '0)) |=> (!mute || dac_off));

  p_flag_after_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zflag_left) |-> $past(smp_valid && pcm_left == '0));

  p_pad_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pad_l_oe && !pad_r_oe) |-> (!pad_l_out && !pad_r_out));

  p_hold_no_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(held_l));
endmodule

bind dac_zero_mute dac_zero_mute_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
  .pcm_left(pcm_left), .pcm_right(pcm_right),
  .dac_off(dac_off), .amute_en(amute_en), .dsd_mode(dsd_mode),
  .out_left(out_left), .out_right(out_right), .mute(mute),
  .zflag_left(zflag_left), .pad_l_out(pad_l_out), .pad_r_out(pad_r_out),
  .pad_l_oe(pad_l_oe), .pad_r_oe(pad_r_oe), .held_l(held_l)
);

// File: tb/test_dac_zero_mute.sv
module test_dac_zero_mute;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 24;
  localparam int RUN = 1024;

  logic clk = 0, rst_n = 0, smp_valid = 0;
  logic [DW-1:0] pcm_left = '0, pcm_right = '0;
  logic dac_off = 0, amute_en = 0, dsd_mode = 0, fbyp_mode = 0, stereo_sel = 0;
  logic pin_out_sel = 0, par_bit = 0, pad_l_in = 0, pad_r_in = 0;
  logic [DW-1:0] out_left, out_right;
  logic mute, zflag_left, zflag_right, pad_l_out, pad_r_out, pad_l_oe, pad_r_oe;
  logic bs_left, bs_right;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_zero_mute #(.DATA_W(DW), .ZERO_RUN(RUN)) i_dac_zero_mute (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .pcm_left(pcm_left), .pcm_right(pcm_right),
    .dac_off(dac_off), .amute_en(amute_en), .dsd_mode(dsd_mode),
    .fbyp_mode(fbyp_mode), .stereo_sel(stereo_sel), .pin_out_sel(pin_out_sel),
    .par_bit(par_bit), .pad_l_in(pad_l_in), .pad_r_in(pad_r_in),
    .out_left(out_left), .out_right(out_right), .mute(mute),
    .zflag_left(zflag_left), .zflag_right(zflag_right),
    .pad_l_out(pad_l_out), .pad_r_out(pad_r_out),
    .pad_l_oe(pad_l_oe), .pad_r_oe(pad_r_oe),
    .bs_left(bs_left), .bs_right(bs_right)
  );

  localparam int NVEC = 6;
  localparam logic [2*DW-1:0] VEC [NVEC] = '{
    {24'h000123, 24'hFFFEDD},
    {24'h7FFFFF, 24'h800000},
    {24'h000000, 24'h000456},
    {24'h000789, 24'h000000},
    {24'hFFFFFF, 24'h000001},
    {24'h5A5A5A, 24'hA5A5A5}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [DW-1:0] l, input logic [DW-1:0] r);
    @(negedge clk);
    pcm_left = l; pcm_right = r; smp_valid = 1;
    @(negedge clk);
    smp_valid = 0;
  endtask

  task automatic zeros(input int n);
    for (int i = 0; i < n; i++) strobe('0, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 out", {out_left, out_right}, '0);
    chk("R1 mute", mute, 0);
    chk("R1 flags", {zflag_left, zflag_right}, 0);
    chk("R1 oe", {pad_l_oe, pad_r_oe}, 0);

    for (int v = 0; v < NVEC; v++) begin
      strobe(VEC[v][2*DW-1:DW], VEC[v][DW-1:0]);
      chk("R2 pass", {out_left, out_right}, VEC[v]);
    end

    // R12: inputs without strobe ignored
    pcm_left = 24'h111111; pcm_right = '0;
    repeat (4) @(negedge clk);
    chk("R12 hold", {out_left, out_right}, VEC[NVEC-1]);

    // R4 / R8 / R9 with auto-mute off
    zeros(RUN - 1);
    chk("R8 not yet", {zflag_left, zflag_right}, 0);
    zeros(76);
    chk("R4 no mute", mute, 0);
    chk("R8 flags", {zflag_left, zflag_right}, 2'b11);
    chk("R9 quiet pads", {pad_l_oe, pad_r_oe, pad_l_out, pad_r_out}, 0);
    pin_out_sel = 1;
    @(negedge clk);
    chk("R9 flag pads", {pad_l_oe, pad_r_oe, pad_l_out, pad_r_out}, 4'b1111);
    strobe(24'h000010, 24'h0);
    chk("R8 clear left", {zflag_left, zflag_right}, 2'b01);
    chk("R9 pads follow", {pad_l_out, pad_r_out}, 2'b01);
    pin_out_sel = 0;
    @(negedge clk);
    chk("R9 back to input", {pad_l_oe, pad_r_oe, pad_l_out, pad_r_out}, 0);

    // R5 threshold
    amute_en = 1;
    strobe(24'h1, 24'h1);
    zeros(RUN - 1);
    chk("R5 at RUN-1", mute, 0);
    zeros(1);
    chk("R5 at RUN", mute, 1);
    chk("R5 out zero", {out_left, out_right}, '0);
    zeros(2000);
    chk("R8 saturate", {mute, zflag_left, zflag_right}, 3'b111);

    // R6 release
    strobe(24'h0, 24'h000005);
    chk("R6 release", mute, 0);
    chk("R6 value", {out_left, out_right}, {24'h0, 24'h000005});

    // R5 joint run: left saturated, right restarts
    zeros(RUN - 1);
    chk("R5 joint RUN-1", mute, 0);
    zeros(1);
    chk("R5 joint RUN", mute, 1);

    // R7
    dsd_mode = 1;
    @(negedge clk);
    chk("R7 suppress", mute, 0);
    dsd_mode = 0;
    @(negedge clk);
    chk("R7 back", mute, 1);

    // R3
    amute_en = 0;
    dac_off = 1;
    strobe(24'h000007, 24'h000009);
    chk("R3 forced", {mute, out_left, out_right}, {1'b1, 48'h0});
    dac_off = 0;
    @(negedge clk);
    chk("R3 resumed", {mute, out_left, out_right}, {1'b0, 24'h000007, 24'h000009});

    // R10 / R11 routing
    fbyp_mode = 1; stereo_sel = 0; par_bit = 1; pad_l_in = 0; pad_r_in = 0;
    #1 chk("R10 mono", {bs_left, bs_right}, 2'b11);
    stereo_sel = 1; par_bit = 0; pad_l_in = 1; pad_r_in = 0;
    #1 chk("R10 stereo", {bs_left, bs_right}, 2'b10);
    dsd_mode = 1;
    #1 chk("R10 bypass priority", {bs_left, bs_right}, 2'b10);
    pin_out_sel = 1; pad_r_in = 1;
    #1 chk("R11 pads out", {bs_left, bs_right}, 2'b00);
    pin_out_sel = 0; fbyp_mode = 0; pad_l_in = 0;
    #1 chk("R10 dsd pads", {bs_left, bs_right}, 2'b01);
    dsd_mode = 0;
    #1 chk("R10 pcm idle", {bs_left, bs_right}, 2'b00);

    // R1 again: reset mid-run
    strobe(24'h3, 24'h4);
    rst_n = 0;
    #1 chk("R1 async reset", {mute, out_left, out_right}, '0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule